// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects up to 32 interrupt sources and presents the most urgent one to a processor as a single interrupt request, `irq_o`. Software sets up each source through a small register bus. Each source has a mode word that holds a trigger kind and a three-bit urgency level. Each source also has a vector word. A source is switched on or off by writing ones to separate enable and disable command words, and the resulting enable set can be read back.

When the processor takes the interrupt, it reads the acknowledge word. That read returns the vector of the winning source. It also records the winner's urgency level on an internal nesting stack, and from then on only strictly more urgent sources raise `irq_o` again. An end-of-service write pops one stack level. A read made while nothing qualifies returns a programmable fallback vector and changes no state.

Level sources follow the input pin. Edge sources latch a pending flag on the chosen edge. That flag is cleared by a clear command or by the acknowledge that selects that source. Low-level and falling-edge kinds are accepted only on source 0 and on sources marked external by a parameter.

Top module: `irq_vec_ctrl`

## Requirements
- R1: Word 0x42 enables and word 0x43 disables each source n whose bit n is 1 in the written data, and zero bits leave that source unchanged. Word 0x44 reads back the enable set, bit n for source n.
- R2: Mode word n (address n, 0..31) holds the urgency level in bits [2:0] and the trigger kind in bits [5:4]. The trigger codes are 0 high level, 1 rising edge, 2 low level and 3 falling edge. Reads return the stored fields with all other bits zero. Vector word n lives at address 32+n.
- R3: A mode write selecting code 2 or 3 on a source that is neither source 0 nor flagged in EXT_SRC (default: sources 28..31) keeps that source's previous trigger kind, while its level field is still written.
- R4: A level source is pending while its input is at the active level, and stops being pending once the input leaves that level. Changes take effect one clock after the input is sampled.
- R5: An edge source latches pending on its selected edge and stays pending after the input returns. The opposite edge sets nothing. Writing 1 to bit n of word 0x45 clears the latch of source n.
- R6: Among enabled pending sources, the one with the highest level wins, and a tie goes to the lowest index. `irq_o` is 1 when a winner exists and the nesting stack is empty.
- R7: Reading word 0x40 while `irq_o` is 1 returns the winner's vector word, pushes its level onto the nesting stack, and clears the winner's edge latch.
- R8: While the stack is not empty, `irq_o` is 1 only if the winner's level is strictly above the level on top of the stack.
- R9: Reading word 0x40 while `irq_o` is 0 returns the fallback vector held in word 0x41 and leaves the stack unchanged.
- R10: Any write to word 0x46 pops one stack level and has no effect on an empty stack. The stack holds eight levels, and eight such writes always empty it.
- R11: After reset, all sources are disabled, every mode word is 0 (high level, level 0), all vector words and the fallback vector are 0, and the stack is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Raw source inputs, synchronous to clk_i |
| bus_req_i | input | 1 | Bus access strobe, one access per cycle |
| bus_we_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | 7 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the read |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The checker assumes that `src_i` is already synchronous to `clk_i`. It also assumes that the bus carries at most one access per cycle, so a push and a pop never coincide. The bench therefore changes `src_i` and the bus signals only on the falling clock edge and issues accesses one at a time. Because push and pop are exclusive and urgency levels strictly increase up the stack, the checker can treat the eight-level depth bound as an invariant rather than something that needs an overflow path.

// File: rtl/irq_ctrl_pkg.sv
`timescale 1ns/1ps
package irq_ctrl_pkg;
  typedef enum logic [1:0] {
    TRIG_LVL_HI = 2'd0,
    TRIG_RISE   = 2'd1,
    TRIG_LVL_LO = 2'd2,
    TRIG_FALL   = 2'd3
  } trig_e;

  localparam int TYPE_LSB = 4;
  // control word offsets above the two per-source banks
  localparam int OFS_ACK  = 0;
  localparam int OFS_SPU  = 1;
  localparam int OFS_EN   = 2;
  localparam int OFS_DIS  = 3;
  localparam int OFS_MASK = 4;
  localparam int OFS_CLR  = 5;
  localparam int OFS_EOI  = 6;
endpackage

// File: rtl/irq_src_detect.sv
`timescale 1ns/1ps
module irq_src_detect
  import irq_ctrl_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  src_i,
  input  trig_e trig_i,
  input  logic  clr_i,
  output logic  pend_o
);
  logic prev_q, latch_q, hit, is_edge;

  assign is_edge = (trig_i == TRIG_RISE) || (trig_i == TRIG_FALL);
  assign hit = ((trig_i == TRIG_RISE) && src_i && !prev_q) ||
               ((trig_i == TRIG_FALL) && !src_i && prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q <= src_i;
      if (!is_edge)   latch_q <= 1'b0;
      else if (hit)   latch_q <= 1'b1;
      else if (clr_i) latch_q <= 1'b0;
    end
  end

  assign pend_o = is_edge ? latch_q : (prev_q == (trig_i == TRIG_LVL_HI));
endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter #(
  parameter  int NSRC   = 32,
  parameter  int PRIO_W = 3,
  localparam int IDX_W  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]   req_i,
  input  logic [PRIO_W-1:0] prio_i [NSRC],
  output logic              valid_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [PRIO_W-1:0] prio_o
);
  // ascending scan with strict compare keeps the lowest index on ties
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    prio_o  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req_i[i] && (!valid_o || prio_i[i] > prio_o)) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        prio_o  = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_nest_stack.sv
`timescale 1ns/1ps
module irq_nest_stack #(
  parameter  int PRIO_W = 3,
  parameter  int DEPTH  = 8,
  localparam int IW     = $clog2(DEPTH),
  localparam int DW     = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic              pop_i,
  output logic              empty_o,
  output logic [PRIO_W-1:0] top_o,
  output logic [DW-1:0]     depth_o
);
  logic [PRIO_W-1:0] stk_q [DEPTH];
  logic [DW-1:0]     depth_q;
  logic [IW-1:0]     wr_ptr, rd_ptr;

  assign wr_ptr = depth_q[IW-1:0];
  assign rd_ptr = wr_ptr - IW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= '0;
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
    end else if (push_i && depth_q != DW'(DEPTH)) begin
      stk_q[wr_ptr] <= prio_i;
      depth_q       <= depth_q + DW'(1);
    end else if (pop_i && depth_q != '0) begin
      depth_q <= depth_q - DW'(1);
    end
  end

  assign empty_o = (depth_q == '0);
  assign top_o   = stk_q[rd_ptr];
  assign depth_o = depth_q;
endmodule

// File: rtl/irq_vec_ctrl.sv
`timescale 1ns/1ps
module irq_vec_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter  int          NSRC    = 32,
  parameter  int          PRIO_W  = 3,
  parameter  int          DATA_W  = 32,
  parameter  logic [31:0] EXT_SRC = 32'hF000_0000,
  localparam int          ADDR_W  = $clog2(2 * NSRC + 8)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  localparam int STACK_D = 1 << PRIO_W;
  localparam int IDX_W   = $clog2(NSRC);
  localparam int DW      = $clog2(STACK_D + 1);
  localparam int CTRL    = 2 * NSRC;
  localparam logic [NSRC-1:0]   EXT_OK = EXT_SRC[NSRC-1:0] | NSRC'(1);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(CTRL + OFS_ACK);
  localparam logic [ADDR_W-1:0] A_SPU  = ADDR_W'(CTRL + OFS_SPU);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(CTRL + OFS_EN);
  localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(CTRL + OFS_DIS);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(CTRL + OFS_MASK);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(CTRL + OFS_CLR);
  localparam logic [ADDR_W-1:0] A_EOI  = ADDR_W'(CTRL + OFS_EOI);

  trig_e [NSRC-1:0]  trig_q;
  logic [PRIO_W-1:0] prio_q [NSRC];
  logic [DATA_W-1:0] vec_q  [NSRC];
  logic [DATA_W-1:0] spu_q;
  logic [NSRC-1:0]   en_q, pend, clr_vec;

  logic              wr, rd, is_mode, is_vec, ack, eoi, legal;
  logic [IDX_W-1:0]  sel;
  trig_e             wr_trig;

  logic              win_valid, stk_empty;
  logic [IDX_W-1:0]  win_idx;
  logic [PRIO_W-1:0] win_prio, top_prio;
  logic [DW-1:0]     depth;
  logic [DATA_W-1:0] mode_rd;

  assign wr      = bus_req_i && bus_we_i;
  assign rd      = bus_req_i && !bus_we_i;
  assign is_mode = bus_addr_i < ADDR_W'(NSRC);
  assign is_vec  = !is_mode && (bus_addr_i < ADDR_W'(CTRL));
  assign sel     = bus_addr_i[IDX_W-1:0];
  assign wr_trig = trig_e'(bus_wdata_i[TYPE_LSB +: 2]);
  assign legal   = !wr_trig[1] || EXT_OK[sel];
  assign ack     = rd && (bus_addr_i == A_ACK) && irq_o;
  assign eoi     = wr && (bus_addr_i == A_EOI);

  // per-source configuration
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NSRC; i++) begin
        trig_q[i] <= TRIG_LVL_HI;
        prio_q[i] <= '0;
        vec_q[i]  <= '0;
      end
    end else if (wr && is_mode) begin
      prio_q[sel] <= bus_wdata_i[PRIO_W-1:0];
      if (legal) trig_q[sel] <= wr_trig;
    end else if (wr && is_vec) begin
      vec_q[sel] <= bus_wdata_i;
    end
  end

  // global control words
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      spu_q <= '0;
    end else if (wr) begin
      unique case (bus_addr_i)
        A_EN:    en_q  <= en_q | bus_wdata_i[NSRC-1:0];
        A_DIS:   en_q  <= en_q & ~bus_wdata_i[NSRC-1:0];
        A_SPU:   spu_q <= bus_wdata_i;
        default: ;
      endcase
    end
  end

  assign clr_vec = ((wr && bus_addr_i == A_CLR) ? bus_wdata_i[NSRC-1:0] : '0) |
                   (ack ? (NSRC'(1) << win_idx) : '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    irq_src_detect u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .src_i  (src_i[g]),
      .trig_i (trig_q[g]),
      .clr_i  (clr_vec[g]),
      .pend_o (pend[g])
    );
  end

  irq_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
    .req_i   (pend & en_q),
    .prio_i  (prio_q),
    .valid_o (win_valid),
    .idx_o   (win_idx),
    .prio_o  (win_prio)
  );

  irq_nest_stack #(.PRIO_W(PRIO_W), .DEPTH(STACK_D)) u_stk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (ack),
    .prio_i  (win_prio),
    .pop_i   (eoi),
    .empty_o (stk_empty),
    .top_o   (top_prio),
    .depth_o (depth)
  );

  assign irq_o = win_valid && (stk_empty || win_prio > top_prio);

  always_comb begin
    mode_rd = '0;
    mode_rd[PRIO_W-1:0]     = prio_q[sel];
    mode_rd[TYPE_LSB +: 2]  = trig_q[sel];
  end

  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      if (is_mode)                   bus_rdata_o = mode_rd;
      else if (is_vec)               bus_rdata_o = vec_q[sel];
      else if (bus_addr_i == A_ACK)  bus_rdata_o = irq_o ? vec_q[win_idx] : spu_q;
      else if (bus_addr_i == A_SPU)  bus_rdata_o = spu_q;
      else if (bus_addr_i == A_MASK) bus_rdata_o = DATA_W'(en_q);
    end
  end
endmodule

// File: rtl/irq_vec_ctrl_checker.sv
`timescale 1ns/1ps
module irq_vec_ctrl_checker
  import irq_ctrl_pkg::*;
#(
  parameter int          NSRC    = 32,
  parameter int          PRIO_W  = 3,
  parameter int          DATA_W  = 32,
  parameter int          ADDR_W  = 7,
  parameter int          DW      = 4,
  parameter logic [31:0] EXT_SRC = 32'hF000_0000
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_i,
  input logic                  we_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [DATA_W-1:0]     wdata_i,
  input logic                  irq_i,
  input logic [NSRC-1:0]       en_i,
  input logic [NSRC-1:0]       pend_i,
  input logic [DW-1:0]         depth_i,
  input logic [NSRC-1:0][1:0]  trig_i
);
  localparam int STACK_D = 1 << PRIO_W;
  localparam logic [NSRC-1:0]   EXT_OK = EXT_SRC[NSRC-1:0] | NSRC'(1);
  localparam logic [ADDR_W-1:0] A_ACK = ADDR_W'(2 * NSRC + OFS_ACK);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(2 * NSRC + OFS_EN);
  localparam logic [ADDR_W-1:0] A_DIS = ADDR_W'(2 * NSRC + OFS_DIS);
  localparam logic [ADDR_W-1:0] A_EOI = ADDR_W'(2 * NSRC + OFS_EOI);

  logic ack_rd, spur_rd, en_wr, dis_wr, eoi_wr;
  assign ack_rd  = req_i && !we_i && addr_i == A_ACK && irq_i;
  assign spur_rd = req_i && !we_i && addr_i == A_ACK && !irq_i;
  assign en_wr   = req_i && we_i && addr_i == A_EN;
  assign dis_wr  = req_i && we_i && addr_i == A_DIS;
  assign eoi_wr  = req_i && we_i && addr_i == A_EOI;

  p_enable_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_wr |=> ((en_i & $past(wdata_i[NSRC-1:0])) == $past(wdata_i[NSRC-1:0])));

  p_disable_clr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_wr |=> ((en_i & $past(wdata_i[NSRC-1:0])) == '0));

  p_irq_has_source_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> ((en_i & pend_i) != '0));

  p_push_on_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_rd |=> (depth_i == $past(depth_i) + DW'(1)));

  p_depth_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_i <= DW'(STACK_D));

  p_spurious_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spur_rd |=> $stable(depth_i));

  p_pop_on_eoi_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_wr && depth_i != '0) |=> (depth_i == $past(depth_i) - DW'(1)));

  p_eoi_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_wr && depth_i == '0) |=> (depth_i == '0));

  for (genvar g = 0; g < NSRC; g++) begin : g_cls
    if (!EXT_OK[g]) begin : g_int
      p_internal_type_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !trig_i[g][1]);
    end
  end
endmodule

bind irq_vec_ctrl irq_vec_ctrl_checker #(
  .NSRC(NSRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .DW(DW), .EXT_SRC(EXT_SRC)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (bus_req_i),
  .we_i    (bus_we_i),
  .addr_i  (bus_addr_i),
  .wdata_i (bus_wdata_i),
  .irq_i   (irq_o),
  .en_i    (en_q),
  .pend_i  (pend),
  .depth_i (depth),
  .trig_i  (trig_q)
);

// File: tb/irq_vec_ctrl_test.sv
`timescale 1ns/1ps
module irq_vec_ctrl_test;
  localparam logic [6:0] A_ACK = 7'h40, A_SPU = 7'h41, A_EN = 7'h42, A_DIS = 7'h43,
                         A_MASK = 7'h44, A_CLR = 7'h45, A_EOI = 7'h46;
  localparam logic [31:0] SPU = 32'h0000_DEAD;
  // {source pattern, expected acknowledge value}; levels are index mod 8
  localparam logic [63:0] TBL [8] = '{
    {32'h0000_0000, SPU},
    {32'h0000_0008, 32'h103},
    {32'h0000_0028, 32'h105},
    {32'h0000_2020, 32'h105},
    {32'h0000_8082, 32'h107},
    {32'h0001_0100, 32'h108},
    {32'h8000_0004, 32'h11F},
    {32'h0100_0001, 32'h100}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int          errs = 0, checks = 0;
  bit          done = 1'b0;
  logic [31:0] v;

  always #10 clk = ~clk;

  irq_vec_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #5 d = rdata;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_irq(input string r, input logic e);
    settle();
    chk(r, {31'b0, irq}, {31'b0, e});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #55 rst_n = 1'b1;
    // R11 reset state
    settle();
    chk("R11 irq", {31'b0, irq}, 32'h0);
    rd(A_MASK, v);   chk("R11 mask", v, 32'h0);
    rd(7'd5, v);     chk("R11 mode", v, 32'h0);
    rd(7'd37, v);    chk("R11 vector", v, 32'h0);
    rd(A_ACK, v);    chk("R11 fallback", v, 32'h0);

    // table walk: R6 arbitration, R7 vector return, R9 fallback
    wr(A_SPU, SPU);
    for (int n = 0; n < 32; n++) begin
      wr(7'(n), 32'(n % 8));
      wr(7'(32 + n), 32'h100 + 32'(n));
    end
    wr(A_EN, 32'hFFFF_FFFF);
    for (int k = 0; k < 8; k++) begin
      src = TBL[k][63:32];
      chk_irq("R6 irq", TBL[k][31:0] != SPU);
      rd(A_ACK, v);
      chk("R6 winner", v, TBL[k][31:0]);
      src = '0;
      wr(A_EOI, 32'h0);
    end

    // R1 enable/disable commands
    wr(A_DIS, 32'hFFFF_FFFF);
    rd(A_MASK, v);   chk("R1 all off", v, 32'h0);
    wr(A_EN, 32'h0000_00F0);
    wr(A_EN, 32'h0000_0001);
    rd(A_MASK, v);   chk("R1 enable", v, 32'h0000_00F1);
    wr(A_DIS, 32'h0000_0030);
    rd(A_MASK, v);   chk("R1 disable", v, 32'h0000_00C1);
    wr(A_DIS, 32'h0);
    rd(A_MASK, v);   chk("R1 zero bits", v, 32'h0000_00C1);

    // R2/R3 mode words and class limits
    wr(7'd2, 32'h24);  rd(7'd2, v);  chk("R3 internal low rejected", v, 32'h04);
    wr(7'd0, 32'h31);  rd(7'd0, v);  chk("R3 source0 falling", v, 32'h31);
    wr(7'd29, 32'h25); rd(7'd29, v); chk("R3 external low", v, 32'h25);
    wr(7'd3, 32'h12);  rd(7'd3, v);  chk("R2 rising readback", v, 32'h12);

    // R4 low level on source 29
    wr(A_DIS, 32'hFFFF_FFFF);
    wr(A_EN, 32'h2000_0000);
    chk_irq("R4 low active", 1'b1);
    rd(A_ACK, v);    chk("R4 vector", v, 32'h11D);
    wr(A_EOI, 32'h0);
    chk_irq("R4 still active", 1'b1);
    src[29] = 1'b1;
    chk_irq("R4 released", 1'b0);

    // R5 rising edge on source 3
    wr(A_DIS, 32'hFFFF_FFFF);
    wr(A_EN, 32'h0000_0008);
    @(negedge clk); src[3] = 1'b1;
    @(negedge clk); src[3] = 1'b0;
    chk_irq("R5 latched", 1'b1);
    wr(A_CLR, 32'h0000_0008);
    chk_irq("R5 cleared", 1'b0);
    @(negedge clk); src[3] = 1'b1;
    @(negedge clk); src[3] = 1'b0;
    chk_irq("R5 relatched", 1'b1);
    rd(A_ACK, v);    chk("R7 edge vector", v, 32'h103);
    wr(A_EOI, 32'h0);
    chk_irq("R7 ack cleared latch", 1'b0);

    // R5 falling edge on source 0
    wr(A_DIS, 32'hFFFF_FFFF);
    wr(A_EN, 32'h0000_0001);
    @(negedge clk); src[0] = 1'b1;
    chk_irq("R5 rise ignored", 1'b0);
    src[0] = 1'b0;
    chk_irq("R5 fall latched", 1'b1);
    wr(A_CLR, 32'h0000_0001);
    chk_irq("R5 fall cleared", 1'b0);

    // R8/R9/R10 nesting with levels 1,2,4,6 on sources 17,18,20,22
    wr(A_DIS, 32'hFFFF_FFFF);
    wr(A_EN, 32'h0056_0000);
    src = 32'h0004_0000;
    settle();
    rd(A_ACK, v);    chk("R7 first", v, 32'h112);
    src[17] = 1'b1;
    chk_irq("R8 lower blocked", 1'b0);
    src[22] = 1'b1;
    chk_irq("R8 higher passes", 1'b1);
    rd(A_ACK, v);    chk("R8 nested vector", v, 32'h116);
    src[20] = 1'b1;
    chk_irq("R8 mid blocked", 1'b0);
    rd(A_ACK, v);    chk("R9 fallback", v, SPU);
    wr(A_EOI, 32'h0);
    chk_irq("R10 one pop", 1'b1);
    rd(A_ACK, v);    chk("R10 after pop", v, 32'h116);
    for (int i = 0; i < 8; i++) wr(A_EOI, 32'h0);
    src = 32'h0002_0000;
    chk_irq("R10 unwound", 1'b1);
    rd(A_ACK, v);    chk("R10 lowest after unwind", v, 32'h111);
    src = '0;
    wr(A_EOI, 32'h0);

    // R10 full eight-level stack on sources 8..15 (levels 0..7)
    wr(A_DIS, 32'hFFFF_FFFF);
    wr(A_EN, 32'h0000_FF00);
    for (int j = 8; j < 16; j++) begin
      src[j] = 1'b1;
      settle();
      rd(A_ACK, v);
      chk("R10 stack fill", v, 32'h100 + 32'(j));
    end
    chk_irq("R10 full blocks", 1'b0);
    src = '0;
    for (int i = 0; i < 8; i++) wr(A_EOI, 32'h0);
    wr(A_EOI, 32'h0);
    src[8] = 1'b1;
    chk_irq("R10 empty after eight", 1'b1);
    rd(A_ACK, v);    chk("R10 level0 vector", v, 32'h108);
    src = '0;
    wr(A_EOI, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule